// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer Controller

This block watches for a stalled program. A prescaled counter runs from a restart point. If software does not kick it before the selected period ends, the block acts according to its mode. It can raise an interrupt, emit a one-cycle system reset pulse, or do both in turn. In the combined mode, the first timeout raises an interrupt. When the CPU serves that interrupt, the block drops into reset-only mode. If the interrupt is never served, the next timeout resets the system.

Software reaches the block through a single 8-bit control and status register on a plain write strobe and a combinational read bus. The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or status level, and writes can never stall.

Two inputs can override software. An always-on strap input pins the block in reset mode. A watchdog reset flag, held outside the block, keeps the reset-enable bit set. Clearing the reset enable or retuning the period needs a short timed unlock sequence.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset the register reads 0x00. The exception is the reset-enable bit (bit 3), which reads the value of `wd_rflag` at reset. `irq` and `sys_rst` are low.
- R2: The mode is decoded from bit 3 (reset enable) and bit 6 (interrupt enable). {0,0} is stopped, {0,1} is interrupt, {1,0} is reset, and {1,1} is interrupt-then-reset. While `strap_force` is 1 the mode is reset, whatever the bits say. In that case a timeout never sets the flag.
- R3: The prescaler P is bit 5 (MSB) followed by bits 2..0. The period is 2^(BASE_LOG2+min(P,9)) cycles, so codes 10 to 15 act as 9. The timeout action becomes visible that many cycles after the restart edge.
- R4: The count restarts on `kick`. It also restarts on the edge after a mode or prescaler change becomes visible. In the stopped mode the count does not run.
- R5: In interrupt mode a timeout sets the flag (bit 7) and issues no reset. `irq` is high exactly when the flag, bit 6 and `gie` are all 1.
- R6: The flag is cleared by an `irq_ack` pulse or by writing 1 to bit 7. Writing 0 to bit 7 leaves it unchanged. In interrupt mode, `irq_ack` leaves bit 6 set.
- R7: In reset mode every timeout produces a `sys_rst` pulse exactly one cycle wide.
- R8: In interrupt-then-reset mode the first timeout sets the flag without a reset. `irq_ack` clears both bit 7 and bit 6, which moves the block to reset mode, and the following period ends in a reset.
- R9: In interrupt-then-reset mode, a timeout that finds the flag still set issues a reset.
- R10: Writing 1 to both bit 4 and bit 3 while bit 4 reads 0 opens a window. Bit 4 then reads 1 for four cycles. A write in any of the next four edges applies bit 3 and the prescaler, and closes the window.
- R11: Outside the window, a write cannot clear bit 3 or change the prescaler. Setting bit 3 is always accepted.
- R12: While `wd_rflag` is 1, bit 3 reads 1 from the next cycle on, and writes cannot clear it. Once the flag is low, the unlock sequence can clear bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read value |
| kick | input | 1 | Restart the count |
| irq_ack | input | 1 | CPU has vectored to the watchdog interrupt |
| gie | input | 1 | Global interrupt enable |
| strap_force | input | 1 | Always-on strap; 1 forces reset mode |
| wd_rflag | input | 1 | Watchdog reset flag held outside the block |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | One-cycle system reset pulse |

## Verification
The embedded properties check several rules on every cycle:
- the reset pulse is always one cycle wide and comes only from a reset-capable mode;
- the prescaler and a falling reset-enable bit change only through an open window;
- the external flag holds the reset-enable bit;
- the interrupt flag rises only on a timeout, and an acknowledge clears it.

Some behaviour is visible only in the bench scenarios: the exact period for each prescaler code, including the reserved codes; the restart caused by a kick; the two endings of the combined mode; the strap override; and the four-edge boundary of the unlock window.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W  = 8;
  localparam int PRE_W  = 4;
  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_P3   = 5;
  localparam int B_CE   = 4;
  localparam int B_RE   = 3;

  typedef enum logic [1:0] {
    WD_OFF  = 2'd0,
    WD_IRQ  = 2'd1,
    WD_RST  = 2'd2,
    WD_BOTH = 2'd3
  } wd_mode_t;

  function automatic wd_mode_t wd_decode(input logic strap, input logic re, input logic ie);
    if (strap) return WD_RST;
    case ({re, ie})
      2'b00:   return WD_OFF;
      2'b01:   return WD_IRQ;
      2'b10:   return WD_RST;
      default: return WD_BOTH;
    endcase
  endfunction
endpackage

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int BASE_LOG2 = 11,
  parameter int MAX_SEL   = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      restart,
  input  logic [wdog_pkg::PRE_W-1:0] pre,
  output logic                      tmo
);
  localparam int CW = BASE_LOG2 + MAX_SEL;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    int sel;
    sel  = (int'(pre) > MAX_SEL) ? MAX_SEL : int'(pre);
    last = {CW{1'b1}} >> (MAX_SEL - sel);
  end

  assign tmo = run && !restart && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run || restart || tmo) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/wdog_csr.sv
module wdog_csr #(
  parameter int CE_CYCLES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [wdog_pkg::REG_W-1:0] wdata,
  input  logic                       ack,
  input  logic                       both_mode,
  input  logic                       flag_set,
  input  logic                       ext_flag,
  output logic                       flag_q,
  output logic                       ie_q,
  output logic                       re_q,
  output logic [wdog_pkg::PRE_W-1:0] pre_q,
  output logic [wdog_pkg::REG_W-1:0] rdata
);
  import wdog_pkg::*;
  localparam int CEW = $clog2(CE_CYCLES + 1);

  logic           ce_q;
  logic [CEW-1:0] ce_cnt;
  logic           open_req, win_wr;

  assign open_req = wr && !ce_q && wdata[B_CE] && wdata[B_RE];
  assign win_wr   = wr && ce_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b0;
      ce_cnt <= '0;
    end else if (open_req) begin
      ce_q   <= 1'b1;
      ce_cnt <= '0;
    end else if (ce_q) begin
      if (win_wr || ce_cnt == CEW'(CE_CYCLES - 1)) ce_q <= 1'b0;
      ce_cnt <= ce_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_q  <= ext_flag;
      pre_q <= '0;
    end else if (win_wr) begin
      re_q  <= wdata[B_RE] | ext_flag;
      pre_q <= {wdata[B_P3], wdata[2:0]};
    end else begin
      re_q  <= re_q | ext_flag | (wr & wdata[B_RE]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ie_q <= 1'b0;
    else if (wr)              ie_q <= wdata[B_IE];
    else if (ack && both_mode) ie_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          flag_q <= 1'b0;
    else if (flag_set)                   flag_q <= 1'b1;
    else if (ack || (wr && wdata[B_FLAG])) flag_q <= 1'b0;
  end

  assign rdata = {flag_q, ie_q, pre_q[3], ce_q, re_q, pre_q[2:0]};

  assert_pre_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pre_q) |-> $past(wr && ce_q));
  assert_re_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(re_q) |-> $past(wr && ce_q && !ext_flag));
  assert_ext_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ext_flag |=> re_q);
  assert_window_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_q) |-> $past(wr));
  assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(flag_set));
  assert_ie_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ie_q) |-> $past(wr || (ack && both_mode)));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
  parameter int BASE_LOG2 = 11,
  parameter int MAX_SEL   = 9,
  parameter int CE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       kick,
  input  logic       irq_ack,
  input  logic       gie,
  input  logic       strap_force,
  input  logic       wd_rflag,
  output logic       irq,
  output logic       sys_rst
);
  import wdog_pkg::*;

  logic             flag_q, ie_q, re_q;
  logic [PRE_W-1:0] pre_q, pre_prev;
  wd_mode_t         mode, mode_prev;
  logic             tmo, restart, run, flag_set, rst_d;

  assign mode     = wd_decode(strap_force, re_q, ie_q);
  assign run      = (mode != WD_OFF);
  assign restart  = kick || (mode != mode_prev) || (pre_q != pre_prev);
  assign flag_set = tmo && ((mode == WD_IRQ) || (mode == WD_BOTH && !flag_q));
  assign rst_d    = tmo && ((mode == WD_RST) || (mode == WD_BOTH && flag_q));
  assign irq      = flag_q && ie_q && gie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_prev <= WD_OFF;
      pre_prev  <= '0;
      sys_rst   <= 1'b0;
    end else begin
      mode_prev <= mode;
      pre_prev  <= pre_q;
      sys_rst   <= rst_d;
    end
  end

  wdog_csr #(.CE_CYCLES(CE_CYCLES)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata), .ack(irq_ack),
    .both_mode(mode == WD_BOTH), .flag_set(flag_set), .ext_flag(wd_rflag),
    .flag_q(flag_q), .ie_q(ie_q), .re_q(re_q), .pre_q(pre_q), .rdata(bus_rdata)
  );

  wdog_timer #(.BASE_LOG2(BASE_LOG2), .MAX_SEL(MAX_SEL)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .pre(pre_q), .tmo(tmo)
  );

  assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);
  assert_rst_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> $past(mode == WD_RST || mode == WD_BOTH));
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !flag_set) |=> !bus_rdata[7]);
endmodule

// File: tb/sim_wdog_ctrl.sv
module sim_wdog_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, bus_wr = 0, kick = 0, irq_ack = 0, gie = 0;
  logic strap_force = 0, wd_rflag = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq, sys_rst;
  int cyc = 0, total = 0, bad = 0;
  int exp_q[$];
  bit mon_on = 1;

  wdog_ctrl #(.BASE_LOG2(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .kick(kick), .irq_ack(irq_ack), .gie(gie),
    .strap_force(strap_force), .wd_rflag(wd_rflag), .irq(irq), .sys_rst(sys_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // monitor: every reset pulse must match the next expected cycle
  always @(negedge clk) begin
    if (mon_on && sys_rst) begin
      if (exp_q.size() == 0) chk("R7", "unexpected reset pulse", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk("R7", "reset pulse cycle", cyc, e);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask
  task automatic wr(input logic [7:0] d, input logic k);
    bus_wr = 1; bus_wdata = d; kick = k;
    tick();
    bus_wr = 0; kick = 0;
  endtask
  task automatic kick_now(output int k);
    kick = 1; k = cyc;
    tick();
    kick = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk("WD", "watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k, w, a;
    tick(3); rst_n = 1; tick();
    // R1 reset state
    chk("R1", "rdata after reset", bus_rdata, 8'h00);
    chk("R1", "irq after reset", irq, 0);
    // R4 stopped mode does not count
    tick(40);
    chk("R4", "flag while stopped", bus_rdata[7], 0);

    // R5 interrupt mode, R3 period at P=0 (4 cycles)
    gie = 1;
    wr(8'h40, 0); tick(2);
    kick_now(k);
    wait_to(k + 4); chk("R3", "flag before period", bus_rdata[7], 0);
    tick();         chk("R3", "flag at period", bus_rdata[7], 1);
    chk("R5", "irq asserted", irq, 1);
    gie = 0; tick(); chk("R5", "irq gated by gie", irq, 0);
    gie = 1; tick(); chk("R5", "irq back", irq, 1);
    wr(8'h40, 1); chk("R6", "write 0 keeps flag", bus_rdata[7], 1);
    wr(8'hC0, 1); w = cyc;
    chk("R6", "write 1 clears flag", bus_rdata[7], 0);
    wait_to(w + 4); chk("R5", "flag set again", bus_rdata[7], 1);
    irq_ack = 1; tick(); irq_ack = 0;
    chk("R6", "ack clears flag, ie kept", bus_rdata, 8'h40);

    // R10 apply reserved prescaler 15, R3 acts as 9 (2048 cycles)
    wr(8'h58, 0);
    wr(8'h67, 0); chk("R10", "window write applied", bus_rdata, 8'h67);
    wr(8'hE7, 1); w = cyc;
    chk("R3", "flag cleared", bus_rdata[7], 0);
    wait_to(w + 2047); chk("R3", "reserved code before period", bus_rdata[7], 0);
    tick();            chk("R3", "reserved code at period", bus_rdata[7], 1);
    wr(8'h98, 0); wr(8'h03, 0);
    chk("R10", "stopped with P=3", bus_rdata, 8'h03);

    // R10 window length and boundary, R11 lock
    wr(8'h18, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R10", "change enable open", bus_rdata[4], 1); tick();
    end
    chk("R10", "change enable expired", bus_rdata[4], 0);
    wr(8'h00, 0); chk("R11", "late write rejected", bus_rdata, 8'h0B);
    wr(8'h18, 0); tick(3);
    wr(8'h01, 0); chk("R10", "fourth-edge write accepted", bus_rdata, 8'h01);
    wr(8'h0E, 0); chk("R11", "set re ok, prescaler locked", bus_rdata, 8'h09);
    wr(8'h18, 0); wr(8'h03, 0);

    // R7 reset mode with P=3 (32 cycles), R4 kick restart
    wr(8'h18, 0); wr(8'h0B, 0); tick(2);
    kick_now(k); tick(20);
    kick_now(k);
    exp_q.push_back(k + 33); exp_q.push_back(k + 65);
    wait_to(k + 66);
    wr(8'h18, 0); wr(8'h03, 0);
    chk("R7", "all pulses seen", exp_q.size(), 0);

    // R8 combined mode with acknowledge
    wr(8'h18, 0); wr(8'h4B, 0); tick(2);
    kick_now(k);
    wait_to(k + 33);
    chk("R8", "first timeout sets flag", bus_rdata[7], 1);
    chk("R8", "irq in combined mode", irq, 1);
    wait_to(k + 40);
    irq_ack = 1; a = cyc;
    exp_q.push_back(a + 34);
    tick(); irq_ack = 0;
    chk("R8", "ack clears flag and ie", bus_rdata[7:6], 0);
    wait_to(a + 35);
    chk("R8", "reset after ack", exp_q.size(), 0);
    wr(8'h18, 0); wr(8'h03, 0);

    // R9 combined mode without acknowledge
    wr(8'h18, 0); wr(8'h4B, 0); tick(2);
    kick_now(k);
    exp_q.push_back(k + 65);
    wait_to(k + 34); chk("R9", "flag set, no reset yet", bus_rdata[7], 1);
    wait_to(k + 66); chk("R9", "second timeout reset", exp_q.size(), 0);
    wr(8'h98, 0); wr(8'h03, 0);

    // R2 strap forces reset mode
    strap_force = 1; wr(8'h43, 0); tick(2);
    kick_now(k);
    exp_q.push_back(k + 33);
    wait_to(k + 34);
    chk("R2", "strap: no flag on timeout", bus_rdata[7], 0);
    chk("R2", "strap: reset pulse seen", exp_q.size(), 0);
    strap_force = 0; wr(8'h80, 0);

    // R12 external reset flag
    mon_on = 0;
    rst_n = 0; wd_rflag = 1; tick(2); rst_n = 1; tick();
    chk("R1", "reset value with flag", bus_rdata, 8'h08);
    wr(8'h18, 0); wr(8'h00, 0);
    chk("R12", "re held by flag", bus_rdata[3], 1);
    wd_rflag = 0; tick();
    wr(8'h18, 0); wr(8'h00, 0);
    chk("R12", "re cleared after flag drop", bus_rdata, 8'h00);
    wd_rflag = 1; tick(2);
    chk("R12", "flag forces re", bus_rdata[3], 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule